// File: doc/BRIEF.md
# Async Memory Bank Select Controller

This block holds the control registers of an asynchronous external memory interface and turns a memory-side address into chip selects for up to four external banks. A small register port reads and writes one 16-bit global control register and two 32-bit bank timing registers. Each access carries an explicit access width. Width violations and accesses to offsets that hold no register are reported through a two-bit error code.

The banks sit back to back from a fixed window base. Bank `i` covers the range starting at `WIN_BASE + i * 2**BANK_LOG2`. The `BANK_LOG2` parameter accepts 20 (1 MiB banks) or 26 (64 MiB banks). A three-bit enable count in the global control register sets how many banks, counted from bank 0, are live. Any change to that count re-maps the decode on the next clock. The timing fields are only stored; the actual strobe timing is produced elsewhere.

Top module: `async_bank_sel`

## Requirements
- R1: After reset the global control register reads 0x00F2 and both bank control registers read 0xFFC2FFC2. Read data, error code, chip selects and the claimed flag are all zero.
- R2: `reg_size_i` encodes the access width as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = reserved. Any width other than 16 or 32 bits reports error code 1 (width), even at an unmapped offset, and changes no register.
- R3: The global control register at offset 0x0 accepts only 16-bit reads and writes. A 32-bit access to it reports error code 1 and leaves it unchanged.
- R4: Any offset other than 0x0, 0x4 (bank control 0) and 0x8 (bank control 1), accessed with a legal width, reports error code 2 (unmapped). A write there changes no register.
- R5: A 32-bit write to a bank control register replaces all of it. A 16-bit write replaces bits [15:0] and keeps bits [31:16]. A 16-bit read returns bits [15:0], zero-extended.
- R6: Read data and the error code appear in the cycle after the strobe and are zero otherwise. Read data is zero when the access fails or when the write strobe is also high; a write wins over a read.
- R7: The enable count is bits [3:1] of global control. Values 5 to 7 act as 4, which enables every bank.
- R8: An address is claimed by bank `i` only when it lies in bank `i`'s range and `i` is below the clamped count. Addresses below the window, at or above the end of bank 3, or in disabled banks raise no chip select.
- R9: `bank_cs_o` is one-hot or zero and is registered: it reflects the address present at the previous clock edge. `claimed_o` is high in exactly the same cycles as any chip select.
- R10: A new enable count written to global control acts on the decode from the clock after the write, for an address held steady across the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_size_i | input | 2 | Access width code |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the strobe |
| reg_err_o | output | 2 | Error code: 0 none, 1 width, 2 unmapped |
| mem_addr_i | input | ADDR_W | Memory-side address to decode |
| bank_cs_o | output | NUM_BANKS | One-hot bank chip selects |
| claimed_o | output | 1 | Address taken by an enabled bank |

## Verification
Decode addresses are drawn just below the window base, across all four banks and past the window end. Because every enable count from 0 to 7 gets written, a wrong bank index, a missing clamp and a leaky disabled bank each give a different chip-select pattern. Register accesses sweep all sixteen offsets with all four width codes. This separates width errors from unmapped errors at the same offset and catches writes that slip through a failed access. Directed cases cover the half-word merge into a bank register and a count change under a steady address, which shows the decode re-maps one clock after the write.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [1:0] {
    ACC_B8  = 2'd0,
    ACC_B16 = 2'd1,
    ACC_B32 = 2'd2,
    ACC_RSV = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_WIDTH = 2'd1,
    ERR_UNMAP = 2'd2
  } err_code_e;

  localparam int          NUM_BCTL  = 2;
  localparam int          OFF_GCTL  = 0;
  localparam int          OFF_BCTL0 = 4;
  localparam logic [15:0] GCTL_RST  = 16'h00F2;
  localparam logic [31:0] BCTL_RST  = 32'hFFC2_FFC2;
endpackage

// File: rtl/amc_access_chk.sv
module amc_access_chk
  import amc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [1:0]          size_i,
  output logic [1:0]          err_o,
  output logic                sel_gctl_o,
  output logic [NUM_BCTL-1:0] sel_bctl_o
);
  logic [NUM_BCTL-1:0] hit_b;

  always_comb begin
    for (int i = 0; i < NUM_BCTL; i++)
      hit_b[i] = (addr_i == AW'(OFF_BCTL0 + 4 * i));
  end

  // width check outranks the offset check
  always_comb begin
    err_o      = ERR_NONE;
    sel_gctl_o = 1'b0;
    sel_bctl_o = '0;
    if (size_i[1] == size_i[0]) begin
      err_o = ERR_WIDTH;
    end else if (addr_i == AW'(OFF_GCTL)) begin
      if (size_i == ACC_B16) sel_gctl_o = 1'b1;
      else                   err_o      = ERR_WIDTH;
    end else if (hit_b != '0) begin
      sel_bctl_o = hit_b;
    end else begin
      err_o = ERR_UNMAP;
    end
  end
endmodule

// File: rtl/amc_regs.sv
module amc_regs
  import amc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    size_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [1:0]    err_o,
  output logic [2:0]    en_field_o
);
  logic [1:0]          acc_err;
  logic                sel_gctl;
  logic [NUM_BCTL-1:0] sel_bctl;
  logic [15:0]         gctl_q;
  logic [31:0]         bctl_q [NUM_BCTL];
  logic [31:0]         rd_val;
  logic [31:0]         rdata_q;
  logic [1:0]          err_q;
  logic                wr_ok;

  amc_access_chk #(.AW(AW)) u_chk (
    .addr_i     (addr_i),
    .size_i     (size_i),
    .err_o      (acc_err),
    .sel_gctl_o (sel_gctl),
    .sel_bctl_o (sel_bctl)
  );

  assign wr_ok = wr_i && (acc_err == ERR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gctl_q <= GCTL_RST;
    else if (wr_ok && sel_gctl) gctl_q <= wdata_i[15:0];
  end

  for (genvar i = 0; i < NUM_BCTL; i++) begin : g_bctl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bctl_q[i] <= BCTL_RST;
      end else if (wr_ok && sel_bctl[i]) begin
        if (size_i == ACC_B32) bctl_q[i]       <= wdata_i;
        else                   bctl_q[i][15:0] <= wdata_i[15:0];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel_gctl) rd_val = {16'h0, gctl_q};
    for (int i = 0; i < NUM_BCTL; i++)
      if (sel_bctl[i])
        rd_val = (size_i == ACC_B32) ? bctl_q[i] : {16'h0, bctl_q[i][15:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= ERR_NONE;
    end else begin
      rdata_q <= (rd_i && !wr_i && acc_err == ERR_NONE) ? rd_val : '0;
      err_q   <= (rd_i || wr_i) ? acc_err : ERR_NONE;
    end
  end

  assign rdata_o    = rdata_q;
  assign err_o      = err_q;
  assign en_field_o = gctl_q[3:1];

  a_r2_width_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && size_i[1] == size_i[0]) |=> (err_q == ERR_WIDTH));

  a_r3_gctl_width_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(OFF_GCTL) && size_i != ACC_B16) |=> $stable(gctl_q));

  a_r4_unmapped_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i[1] != size_i[0] && addr_i != AW'(0) && addr_i != AW'(4) &&
     addr_i != AW'(8)) |=> ($stable(gctl_q) && $stable(bctl_q[0]) && $stable(bctl_q[1])));

  a_r6_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != ERR_NONE) |-> (rdata_q == '0));
endmodule

// File: rtl/amc_bank_decode.sv
module amc_bank_decode #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h2000_0000,
  parameter int                BANK_LOG2 = 20,
  parameter int                NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           en_field_i,
  input  logic [ADDR_W-1:0]    mem_addr_i,
  output logic [NUM_BANKS-1:0] cs_o,
  output logic                 claimed_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int SPAN_W = BANK_LOG2 + BANK_W;

  if (!(BANK_LOG2 == 20 || BANK_LOG2 == 26)) begin : g_bad_size
    $error("BANK_LOG2 must be 20 or 26");
  end

  logic [2:0]           cnt;
  logic [ADDR_W-1:0]    offset;
  logic                 in_win;
  logic [BANK_W-1:0]    idx;
  logic [NUM_BANKS-1:0] hit;
  logic [NUM_BANKS-1:0] cs_q;
  logic                 claim_q;

  assign cnt    = (en_field_i > 3'(NUM_BANKS)) ? 3'(NUM_BANKS) : en_field_i;
  assign offset = mem_addr_i - WIN_BASE;
  assign in_win = (mem_addr_i >= WIN_BASE) && ((offset >> SPAN_W) == '0);
  assign idx    = offset[BANK_LOG2 +: BANK_W];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_hit
    assign hit[i] = in_win && (idx == BANK_W'(i)) && (int'(cnt) > i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      claim_q <= 1'b0;
    end else begin
      cs_q    <= hit;
      claim_q <= |hit;
    end
  end

  assign cs_o      = cs_q;
  assign claimed_o = claim_q;

  a_r9_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_q));

  a_r9_claim_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_q == (cs_q != '0));

  a_r8_cs_enabled_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_q != '0) |-> ({1'b0, cs_q} < ((NUM_BANKS + 1)'(1) << $past(cnt))));
endmodule

// File: rtl/async_bank_sel.sv
module async_bank_sel #(
  parameter int                REG_AW    = 4,
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h2000_0000,
  parameter int                BANK_LOG2 = 20,
  parameter int                NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [1:0]           reg_size_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic [1:0]           reg_err_o,
  input  logic [ADDR_W-1:0]    mem_addr_i,
  output logic [NUM_BANKS-1:0] bank_cs_o,
  output logic                 claimed_o
);
  logic [2:0] en_field;

  amc_regs #(.AW(REG_AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .size_i     (reg_size_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .err_o      (reg_err_o),
    .en_field_o (en_field)
  );

  amc_bank_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .BANK_LOG2 (BANK_LOG2),
    .NUM_BANKS (NUM_BANKS)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_field_i (en_field),
    .mem_addr_i (mem_addr_i),
    .cs_o       (bank_cs_o),
    .claimed_o  (claimed_o)
  );
endmodule

// File: tb/tb_async_bank_sel.sv
module tb_async_bank_sel;
  localparam int          CLK_P = 10;
  localparam logic [31:0] BASE  = 32'h2000_0000;
  localparam int          BL2   = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  err;
  logic [31:0] maddr = '0;
  logic [3:0]  cs;
  logic        claimed;

  int checks = 0, errors = 0;
  logic [15:0] m_gctl;
  logic [31:0] m_b0, m_b1;

  always #(CLK_P/2) clk = ~clk;

  async_bank_sel #(.WIN_BASE(BASE), .BANK_LOG2(BL2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_size_i(size), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_err_o(err),
    .mem_addr_i(maddr), .bank_cs_o(cs), .claimed_o(claimed));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_err(input logic [3:0] a, input logic [1:0] s);
    if (s == 2'd0 || s == 2'd3) return 2'd1;
    if (a == 4'h0) return (s == 2'd1) ? 2'd0 : 2'd1;
    if (a == 4'h4 || a == 4'h8) return 2'd0;
    return 2'd2;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a, input logic [1:0] s);
    logic [31:0] v;
    if (exp_err(a, s) != 2'd0) return 32'h0;
    if (a == 4'h0) return {16'h0, m_gctl};
    v = (a == 4'h4) ? m_b0 : m_b1;
    return (s == 2'd2) ? v : {16'h0, v[15:0]};
  endfunction

  function automatic logic [3:0] exp_cs(input logic [31:0] a);
    int cnt;
    logic [31:0] off;
    int idx;
    cnt = int'(m_gctl[3:1]);
    if (cnt > 4) cnt = 4;
    if (a < BASE) return 4'h0;
    off = a - BASE;
    if (off >= (32'h1 << (BL2 + 2))) return 4'h0;
    idx = int'(off >> BL2);
    return (idx < cnt) ? 4'(1 << idx) : 4'h0;
  endfunction

  // one access; checks the response one cycle later, then updates the model
  task automatic acc(input bit w, input bit r, input logic [3:0] a, input logic [1:0] s,
                     input logic [31:0] d, input string tag);
    logic [1:0] e;
    logic [31:0] x;
    @(negedge clk);
    wr = w; rd = r; addr = a; size = s; wdata = d;
    e = exp_err(a, s);
    x = (r && !w) ? exp_rd(a, s) : 32'h0;
    @(negedge clk);
    chk(err == e, {tag, " err"}, 32'(err), 32'(e));
    chk(rdata == x, {tag, " rdata"}, rdata, x);
    wr = 1'b0; rd = 1'b0;
    if (w && e == 2'd0) begin
      if (a == 4'h0) m_gctl = d[15:0];
      else if (a == 4'h4) m_b0 = (s == 2'd2) ? d : {m_b0[31:16], d[15:0]};
      else m_b1 = (s == 2'd2) ? d : {m_b1[31:16], d[15:0]};
    end
  endtask

  task automatic dec(input logic [31:0] a, input string tag);
    logic [3:0] x;
    @(negedge clk);
    maddr = a;
    x = exp_cs(a);
    @(negedge clk);
    chk(cs == x, {tag, " cs"}, 32'(cs), 32'(x));
    chk(claimed == (x != 0), {tag, " claimed"}, 32'(claimed), 32'(x != 0));
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_gctl = 16'h00F2; m_b0 = 32'hFFC2_FFC2; m_b1 = 32'hFFC2_FFC2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdata == 0 && err == 0, "R1 port idle", {rdata[29:0], err}, 32'h0);
    chk(cs == 0 && !claimed, "R1 cs idle", 32'(cs), 32'h0);
    acc(0, 1, 4'h0, 2'd1, 0, "R1 gctl");
    acc(0, 1, 4'h4, 2'd2, 0, "R1 bctl0");
    acc(0, 1, 4'h8, 2'd2, 0, "R1 bctl1");
    // R8 reset count of one bank
    dec(BASE + 32'h10, "R8 bank0");
    dec(BASE + 32'h0010_0000, "R8 bank1 off");
    // R2 width error before unmapped
    acc(1, 0, 4'hC, 2'd0, 32'h1, "R2 b8 unmapped");
    acc(0, 1, 4'hC, 2'd3, 0, "R2 rsv unmapped");
    acc(1, 0, 4'h4, 2'd0, 32'h0BAD_0BAD, "R2 b8 write");
    acc(0, 1, 4'h4, 2'd2, 0, "R2 unchanged");
    // R3 gctl 16-bit only
    acc(1, 0, 4'h0, 2'd2, 32'h0000_0008, "R3 w32");
    acc(0, 1, 4'h0, 2'd2, 0, "R3 r32");
    acc(0, 1, 4'h0, 2'd1, 0, "R3 unchanged");
    // R4 unmapped
    acc(1, 0, 4'h2, 2'd2, 32'hDEAD_BEEF, "R4 w off2");
    acc(1, 0, 4'hC, 2'd1, 32'hDEAD_BEEF, "R4 w offC");
    acc(0, 1, 4'hC, 2'd2, 0, "R4 r offC");
    acc(0, 1, 4'h4, 2'd2, 0, "R4 b0 kept");
    acc(0, 1, 4'h8, 2'd2, 0, "R4 b1 kept");
    // R5 half-word merge
    acc(1, 0, 4'h4, 2'd2, 32'h1234_5678, "R5 w32");
    acc(1, 0, 4'h4, 2'd1, 32'hFFFF_ABCD, "R5 w16");
    acc(0, 1, 4'h4, 2'd2, 0, "R5 r32");
    acc(0, 1, 4'h4, 2'd1, 0, "R5 r16");
    // R6 write wins over read
    acc(1, 1, 4'h8, 2'd2, 32'hCAFE_0001, "R6 rd+wr");
    acc(0, 1, 4'h8, 2'd2, 0, "R6 after");
    // R7 clamp
    acc(1, 0, 4'h0, 2'd1, 32'h0000_000E, "R7 cnt7");
    dec(BASE + 32'h0030_0004, "R7 bank3 cnt7");
    acc(1, 0, 4'h0, 2'd1, 32'h0000_0008, "R7 cnt4");
    dec(BASE + 32'h0030_0004, "R7 bank3 cnt4");
    dec(BASE + 32'h003F_FFFF, "R8 last byte");
    dec(BASE + 32'h0040_0000, "R8 past end");
    dec(BASE - 32'h1, "R8 below");
    acc(1, 0, 4'h0, 2'd1, 32'h0000_0000, "R7 cnt0");
    dec(BASE, "R8 none enabled");
    // R10 live remap under a held address
    acc(1, 0, 4'h0, 2'd1, 32'h0000_0004, "R10 cnt2");
    dec(BASE + 32'h0020_0000, "R10 bank2 off");
    acc(1, 0, 4'h0, 2'd1, 32'h0000_0006, "R10 cnt3");
    @(negedge clk);
    chk(cs == 4'b0100, "R10 remap", 32'(cs), 32'h4);
    // R9 registered decode: a one-cycle address shows in the following cycle
    @(negedge clk);
    maddr = BASE + 32'h0010_0000;
    @(negedge clk);
    maddr = BASE - 32'h100;
    chk(cs == 4'b0010 && claimed, "R9 registered", 32'(cs), 32'h2);
    @(negedge clk);
    chk(cs == 4'b0000 && !claimed, "R9 cleared", 32'(cs), 32'h0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 1) == 0) begin
        logic [3:0] a;
        logic [31:0] d;
        bit w;
        a = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'($urandom_range(0, 2) * 4);
        w = 1'($urandom);
        d = $urandom;
        acc(w, !w, a, 2'($urandom), d, w ? "R2 R4 R5 rand wr" : "R3 R6 rand rd");
      end else begin
        dec(BASE - 32'h1000 + ($urandom % 32'h0050_0000), "R7 R8 R9 rand dec");
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule